// File: doc/BRIEF.md
# Interleaved Four-Bank Cache Line Fill Controller

This controller refills one 16-word cache block after a miss. The memory behind it is split into four independent banks, each one word wide, and all four share a single one-word bus. The controller accepts a miss request with a block-aligned word address. It spends one cycle putting that address on the bus, then starts the four banks on staggered cycles, so each bank's fetches overlap with the others. Words reach the cache write port strictly in word order, W0 first, at most one per cycle.

Bank k serves words k, k+4, k+8 and k+12. It increments its own address by four after each fetch. A bank holds its address stable for the five-cycle access. It captures the result in a holding register, and in the same cycle that word occupies the bus it already applies its next address. The CPU stall output stays high from the address cycle until the cycle that writes W15. A one-cycle done pulse then reports the miss penalty in cycles. While a fill runs, the ready output is low, so any new miss request waits.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset, ready is 1, stall is 0, and no address cycle, cache write or done pulse is signalled. A miss is accepted on a rising edge where miss_req and ready are both 1.
- R2: addr_phase is 1 for exactly one cycle, the cycle after acceptance (cycle 1 of the fill), and no cache write occurs in that cycle.
- R3: Bank k presents base+k in cycles 2+k to 6+k, base+k+4 in 7+k to 11+k, base+k+8 in 12+k to 16+k, and base+k+12 in 17+k to 21+k. Bank k's address is bits [16k+15:16k] of bank_addr.
- R4: Word i of the block, with value equal to the bank read of address base+i, is written with cwr_idx=i in cycle 7+5*(i/4)+(i%4). Words therefore arrive in ascending order.
- R5: At most one cache write occurs per cycle. Cycles 1 to 6 and every fifth cycle 11, 16 and 21 carry no write.
- R6: stall is 1 from cycle 1 through cycle 25, the cycle that writes W15, and is 0 in cycle 26.
- R7: fill_done is a one-cycle pulse in cycle 26 with fill_cycles equal to 25, counting from the address cycle through the last bus cycle.
- R8: A request present in cycle 26 is accepted there, and the next fill's address cycle follows at once.
- R9: While a fill is in progress, ready is 0. A request held high during that time starts nothing and does not disturb the running fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_req | input | 1 | Miss request |
| miss_addr | input | 16 | Block-aligned word address of the missing block |
| miss_ready | output | 1 | Controller idle and able to accept a request |
| stall | output | 1 | CPU stall while the block is being filled |
| addr_phase | output | 1 | Bus carries the block address this cycle |
| bank_addr | output | 64 | Four 16-bit bank addresses, bank k in bits [16k+15:16k] |
| bank_rdata | input | 128 | Four 32-bit bank read words, bank k in bits [32k+31:32k] |
| cwr_en | output | 1 | Cache write strobe, one word on the bus |
| cwr_idx | output | 4 | Word index within the block being written |
| cwr_data | output | 32 | Word being written |
| fill_done | output | 1 | One-cycle completion pulse |
| fill_cycles | output | 6 | Miss penalty in cycles, valid with fill_done |

## Verification
The completion pulse of one fill and the acceptance of the next miss can fall in the same cycle. In that cycle the done pulse and fill_cycles are still being reported while a new address cycle is scheduled. The bench provokes this by holding miss_req high with a new address through a whole fill, so the request is ignored while busy and taken in the done cycle. It then checks that the old fill reports 25 cycles, and that the new fill's address cycle, bank addresses and word timing match the expected schedule exactly.

// File: rtl/line_fill_pkg.sv
package line_fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_FILL = 2'd2
  } fill_state_e;
endpackage

// File: rtl/fill_bank_seq.sv
module fill_bank_seq #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int NB      = 4,
  parameter int LAT     = 5,
  parameter int FETCHES = 4,
  parameter int IDX     = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          grant,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] hold,
  output logic          hold_vld
);
  localparam int LW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam int FW = $clog2(FETCHES) + 1;

  logic [AW-1:0] addr_q, addr_n;
  logic [LW-1:0] lat_q, lat_n;
  logic [FW-1:0] left_q, left_n;
  logic          busy_q, busy_n;
  logic [DW-1:0] hold_q;
  logic          hv_q, hv_n;
  logic          capture;

  assign capture = busy_q && (lat_q == LW'(LAT - 1));

  always_comb begin
    addr_n = addr_q;
    lat_n  = lat_q;
    left_n = left_q;
    busy_n = busy_q;
    hv_n   = hv_q;
    if (grant) hv_n = 1'b0;
    if (start) begin
      addr_n = base + AW'(IDX);
      lat_n  = '0;
      left_n = FW'(FETCHES - 1);
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (capture) begin
        hv_n = 1'b1;
        if (left_q != '0) begin
          addr_n = addr_q + AW'(NB);
          lat_n  = '0;
          left_n = left_q - 1'b1;
        end else begin
          busy_n = 1'b0;
        end
      end else begin
        lat_n = lat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lat_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      hv_q   <= 1'b0;
    end else begin
      addr_q <= addr_n;
      lat_q  <= lat_n;
      left_q <= left_n;
      busy_q <= busy_n;
      hv_q   <= hv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= rdata;
  end

  assign addr     = addr_q;
  assign hold     = hold_q;
  assign hold_vld = hv_q;

  // R3: address held for the whole access
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && lat_q != '0) |-> (addr_q == $past(addr_q)));

  // R4: a captured word may not overwrite one still waiting for the bus
  p_hold_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!hv_q || grant));
endmodule

// File: rtl/fill_bus_arb.sv
module fill_bus_arb #(
  parameter int DW  = 32,
  parameter int NB  = 4,
  parameter int WPB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic [NB-1:0]    hv,
  input  logic [NB*DW-1:0] hold,
  output logic [NB-1:0]    grant,
  output logic             wr_en,
  output logic [$clog2(WPB)-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             last
);
  localparam int WIW = $clog2(WPB);
  localparam int BIW = $clog2(NB);

  logic [WIW-1:0] widx_q, widx_n;
  logic [BIW-1:0] sel;

  assign sel = widx_q[BIW-1:0];

  always_comb begin
    grant = '0;
    if (active && hv[sel]) grant[sel] = 1'b1;
  end

  assign wr_en   = |grant;
  assign wr_idx  = widx_q;
  assign wr_data = hold[sel*DW +: DW];
  assign last    = wr_en && (widx_q == WIW'(WPB - 1));

  always_comb begin
    widx_n = widx_q;
    if (clr)        widx_n = '0;
    else if (wr_en) widx_n = widx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) widx_q <= '0;
    else        widx_q <= widx_n;
  end

  // R5: the shared bus carries at most one word per cycle
  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import line_fill_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int NB  = 4,
  parameter int WPB = 16,
  parameter int LAT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_req,
  input  logic [AW-1:0]    miss_addr,
  output logic             miss_ready,
  output logic             stall,
  output logic             addr_phase,
  output logic [NB*AW-1:0] bank_addr,
  input  logic [NB*DW-1:0] bank_rdata,
  output logic             cwr_en,
  output logic [$clog2(WPB)-1:0] cwr_idx,
  output logic [DW-1:0]    cwr_data,
  output logic             fill_done,
  output logic [$clog2(1 + NB + LAT*(WPB/NB))+1-1:0] fill_cycles
);
  localparam int FETCHES = WPB / NB;
  localparam int OFFW    = $clog2(WPB);
  localparam int MAXCYC  = 1 + NB + LAT * FETCHES;
  localparam int CW      = $clog2(MAXCYC) + 1;

  logic srst_a, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_a <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      srst_a <= 1'b1;
      srst_n <= srst_a;
    end
  end

  fill_state_e   state_q, state_n;
  logic [CW-1:0] cyc_q, cyc_n;
  logic [AW-1:0] base_q;
  logic          accept, last;
  logic [CW-1:0] cycles_q;
  logic          done_q;
  logic [NB-1:0] start, grant, hv;
  logic [NB*DW-1:0] hold;

  assign miss_ready = (state_q == ST_IDLE);
  assign accept     = miss_req && miss_ready;
  assign stall      = (state_q != ST_IDLE);
  assign addr_phase = (state_q == ST_ADDR);

  always_comb begin
    state_n = state_q;
    cyc_n   = cyc_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_n = ST_ADDR;
        cyc_n   = CW'(1);
      end
      ST_ADDR: begin
        state_n = ST_FILL;
        cyc_n   = cyc_q + 1'b1;
      end
      default: begin
        cyc_n = cyc_q + 1'b1;
        if (last) state_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
    end else begin
      state_q <= state_n;
      cyc_q   <= cyc_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     base_q <= '0;
    else if (accept) base_q <= {miss_addr[AW-1:OFFW], {OFFW{1'b0}}};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_q   <= 1'b0;
      cycles_q <= '0;
    end else begin
      done_q <= last;
      if (last) cycles_q <= cyc_q;
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_bank
    assign start[k] = (state_q != ST_IDLE) && (cyc_q == CW'(k + 1));
    fill_bank_seq #(
      .AW(AW), .DW(DW), .NB(NB), .LAT(LAT), .FETCHES(FETCHES), .IDX(k)
    ) u_bank (
      .clk      (clk),
      .rst_n    (srst_n),
      .start    (start[k]),
      .base     (base_q),
      .grant    (grant[k]),
      .rdata    (bank_rdata[k*DW +: DW]),
      .addr     (bank_addr[k*AW +: AW]),
      .hold     (hold[k*DW +: DW]),
      .hold_vld (hv[k])
    );
  end

  fill_bus_arb #(.DW(DW), .NB(NB), .WPB(WPB)) u_arb (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (accept),
    .active  (state_q == ST_FILL),
    .hv      (hv),
    .hold    (hold),
    .grant   (grant),
    .wr_en   (cwr_en),
    .wr_idx  (cwr_idx),
    .wr_data (cwr_data),
    .last    (last)
  );

  assign fill_done   = done_q;
  assign fill_cycles = cycles_q;

  // R2: the address cycle lasts exactly one cycle and carries no data
  p_addr_once_r2: assert property (@(posedge clk) disable iff (!srst_n)
    addr_phase |=> !addr_phase);
  p_addr_nowrite_r2: assert property (@(posedge clk) disable iff (!srst_n)
    addr_phase |-> !cwr_en);
  // R6: every cache write happens while the CPU is stalled
  p_write_stalled_r6: assert property (@(posedge clk) disable iff (!srst_n)
    cwr_en |-> stall);
  // R7: completion follows the final word and comes with the idle state
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!srst_n)
    fill_done |-> (miss_ready && $past(cwr_en)));
  // R9: no request is taken while a fill runs
  p_holdoff_r9: assert property (@(posedge clk) disable iff (!srst_n)
    stall |-> !miss_ready);
endmodule

// File: tb/line_fill_ctrl_test.sv
module line_fill_ctrl_test;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NB = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             miss_req;
  logic [AW-1:0]    miss_addr;
  logic             miss_ready, stall, addr_phase;
  logic [NB*AW-1:0] bank_addr;
  logic [NB*DW-1:0] bank_rdata;
  logic             cwr_en;
  logic [3:0]       cwr_idx;
  logic [DW-1:0]    cwr_data;
  logic             fill_done;
  logic [5:0]       fill_cycles;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  line_fill_ctrl uut (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .stall(stall), .addr_phase(addr_phase),
    .bank_addr(bank_addr), .bank_rdata(bank_rdata), .cwr_en(cwr_en),
    .cwr_idx(cwr_idx), .cwr_data(cwr_data), .fill_done(fill_done),
    .fill_cycles(fill_cycles)
  );

  function automatic logic [DW-1:0] bank_val(input logic [AW-1:0] a);
    return {a ^ 16'h3C5A, ~a};
  endfunction

  always_comb begin
    for (int k = 0; k < NB; k++)
      bank_rdata[k*DW +: DW] = bank_val(bank_addr[k*AW +: AW]);
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle();
    check("R1", "ready idle", miss_ready, 1);
    check("R1", "stall idle", stall, 0);
    check("R1", "addr_phase idle", addr_phase, 0);
    check("R1", "write idle", cwr_en, 0);
    check("R1", "done idle", fill_done, 0);
  endtask

  // Entered at a negedge: drives the request, then walks cycles 1..26.
  task automatic run_fill(input logic [AW-1:0] base, input bit chain,
                          input logic [AW-1:0] next_base);
    miss_req  = 1'b1;
    miss_addr = base;
    check("R1", "ready at request", miss_ready, 1);
    for (int t = 1; t <= 26; t++) begin
      @(negedge clk);
      if (t == 1) begin
        if (chain) miss_addr = next_base;
        else       miss_req  = 1'b0;
      end
      check("R2", "addr_phase", addr_phase, (t == 1));
      check("R6", "stall", stall, (t <= 25));
      check("R9", "ready during fill", miss_ready, (t == 26));
      for (int k = 0; k < NB; k++) begin
        if (t >= 2 + k && t <= 21 + k)
          check("R3", $sformatf("bank%0d addr t=%0d", k, t),
                bank_addr[k*AW +: AW],
                base + AW'(k) + AW'(4 * ((t - 2 - k) / 5)));
      end
      if (t >= 7 && t <= 25 && ((t - 7) % 5) != 4) begin
        int w;
        w = 4 * ((t - 7) / 5) + ((t - 7) % 5);
        check("R4", $sformatf("write en t=%0d", t), cwr_en, 1);
        check("R4", $sformatf("write idx t=%0d", t), cwr_idx, w);
        check("R4", $sformatf("write data t=%0d", t), cwr_data,
              bank_val(base + AW'(w)));
      end else begin
        check("R5", $sformatf("no write t=%0d", t), cwr_en, 0);
      end
      check("R7", "done pulse", fill_done, (t == 26));
      if (t == 26) check("R7", "fill cycles", fill_cycles, 25);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] bases [8];
    rst_n     = 1'b0;
    miss_req  = 1'b0;
    miss_addr = '0;
    for (int i = 0; i < 8; i++)
      bases[i] = AW'((i * 16'h1230 + i * 16'h0010)) & 16'hFFF0;
    bases[7] = 16'hFFF0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle();
    // R8: even i chains into i+1; odd i ends with idle cycles
    for (int i = 0; i < 8; i++) begin
      bit ch;
      ch = (i % 2 == 0) && (i < 7);
      run_fill(bases[i], ch, ch ? bases[i+1] : '0);
      if (!ch) begin
        repeat (2) begin
          @(negedge clk);
          check_idle();
        end
      end else begin
        check("R8", "ready in done cycle", miss_ready, 1);
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule